// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Unit

This block lets each of N cores (four by default) ring a doorbell interrupt on any other core. All cores share a single command port. A core claims the port, writes a 16-bit command word with a one-cycle write strobe, and gives its own core number on a requester input. The unit keeps, for every receiving core, a vector with one bit per sender. A receiving core's interrupt line is the registered OR of its vector.

Two senders that ring the same receiver before it responds produce a single asserted line, and the receiver's vector then shows both senders. The receiver reads its vector with a who-rang command. It then retires each sender with a separate acknowledge command. The line drops only after the last sender has been retired. Any core can also read whether a given core has a doorbell pending.

The command port is a plain strobe with no back-pressure: it accepts one command per cycle. Arbitration between cores is done outside the block.

Top module: `xcore_doorbell`

## Requirements
- R1: The command word holds the opcode in bits [7:0] and a core-number argument in bits [15:8]. A strobe sampled at clock edge k updates the sender vectors and the readback at edge k+1, and the interrupt lines at edge k+2.
- R2: Opcode 0x01 (ring) from requester s with argument t sets bit s of core t's sender vector, and core t's interrupt line then asserts.
- R3: A ring whose argument equals the requester changes nothing. No core can ring itself.
- R4: Opcode 0x02 (peek) with argument t loads the readback with 1 if core t's sender vector has any bit set, and with 0 otherwise. The value is zero-extended to N bits.
- R5: Opcode 0x03 (who-rang) loads the readback with the requester's own sender vector. Bit s stands for sender s, so a single sender reads 1, 2, 4 or 8 for cores 0 to 3.
- R6: Rings from several senders to one target before any acknowledge give one asserted line and several set bits in that target's vector.
- R7: Opcode 0x04 (acknowledge) from requester t with argument s clears only bit s of core t's vector. All other bits are kept.
- R8: A core's interrupt line stays high while any bit of its vector is set. It goes low one cycle after the last bit clears.
- R9: A ring to a target that already holds the sender's bit leaves every vector unchanged.
- R10: Any command whose argument or requester is N or more is ignored, and so is any opcode other than 0x01 to 0x04. Vectors, lines and readback all keep their values.
- R11: After reset all vectors, all interrupt lines and the readback are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle per command |
| cmd_core | input | ID_W | Core number of the core that owns the command port |
| cmd_word | input | 16 | Command word: opcode [7:0], argument [15:8] |
| readback | output | N | Result of the last peek or who-rang command |
| irq | output | N | Doorbell interrupt line, one per core |

## Verification
The bench sweeps every sender and target pair. This separates the self-ring case from real rings, and it shows that each vector bit is indexed by sender and not by target. It then rings one target from three senders and retires them one at a time. That run shows how rings merge, that an acknowledge clears only its own bit, and the exact cycle at which the line drops. Repeat rings, out-of-range arguments (4, 9, 255) and unused opcodes come last, each followed by a readback. They show that ignored commands leave all state untouched, which a design that only stores the last command would fail.

// File: rtl/xcd_pkg.sv
package xcd_pkg;

  typedef enum logic [7:0] {
    OP_RING = 8'h01,
    OP_PEEK = 8'h02,
    OP_WHO  = 8'h03,
    OP_ACK  = 8'h04
  } xcd_op_e;

  typedef struct packed {
    logic       live;
    logic [7:0] op;
    logic [7:0] arg;
    logic [7:0] core;
  } xcd_cmd_t;

endpackage

// File: rtl/xcd_cmd_stage.sv
module xcd_cmd_stage #(
  parameter int N    = 4,
  parameter int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [ID_W-1:0] cmd_core,
  input  logic [15:0]     cmd_word,
  output logic            do_ring,
  output logic            do_peek,
  output logic            do_who,
  output logic            do_ack,
  output logic [ID_W-1:0] req_id,
  output logic [ID_W-1:0] arg_id
);
  import xcd_pkg::*;

  xcd_cmd_t cmd_q;
  logic     arg_ok, req_ok, base_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else begin
      cmd_q.live <= cmd_we;
      if (cmd_we) begin
        cmd_q.op   <= cmd_word[7:0];
        cmd_q.arg  <= cmd_word[15:8];
        cmd_q.core <= 8'(cmd_core);
      end
    end
  end

  always_comb begin
    arg_ok  = 32'(cmd_q.arg) < N;
    req_ok  = 32'(cmd_q.core) < N;
    base_ok = cmd_q.live && arg_ok && req_ok;
    req_id  = cmd_q.core[ID_W-1:0];
    arg_id  = cmd_q.arg[ID_W-1:0];
    do_ring = base_ok && (cmd_q.op == OP_RING) && (req_id != arg_id);
    do_peek = base_ok && (cmd_q.op == OP_PEEK);
    do_who  = base_ok && (cmd_q.op == OP_WHO);
    do_ack  = base_ok && (cmd_q.op == OP_ACK);
  end

  // R10: an argument at or past N never produces an action in the next cycle
  p_range_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && 32'(cmd_word[15:8]) >= N) |=> !(do_ring || do_peek || do_who || do_ack));

  // at most one action per command
  p_one_action_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({do_ring, do_peek, do_who, do_ack}) <= 1);

endmodule

// File: rtl/xcd_sender_matrix.sv
module xcd_sender_matrix #(
  parameter int N    = 4,
  parameter int ID_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                do_ring,
  input  logic                do_ack,
  input  logic [ID_W-1:0]     req_id,
  input  logic [ID_W-1:0]     arg_id,
  output logic [N-1:0][N-1:0] src_vec
);

  for (genvar t = 0; t < N; t++) begin : g_tgt
    for (genvar s = 0; s < N; s++) begin : g_snd
      logic set_hit, clr_hit;
      always_comb begin
        set_hit = do_ring && (32'(arg_id) == t) && (32'(req_id) == s) && (s != t);
        clr_hit = do_ack  && (32'(req_id) == t) && (32'(arg_id) == s);
      end

      always_ff @(posedge clk) begin
        if (!rst_n)       src_vec[t][s] <= 1'b0;
        else if (set_hit) src_vec[t][s] <= 1'b1;
        else if (clr_hit) src_vec[t][s] <= 1'b0;
      end

      // R2: a ring from s to t leaves t's bit s set
      p_ring_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ring && 32'(arg_id) == t && 32'(req_id) == s && s != t) |=> src_vec[t][s]);

      // R7: an acknowledge by t for s clears that bit only
      p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ack && 32'(req_id) == t && 32'(arg_id) == s) |=> !src_vec[t][s]);

      // R7: acknowledging a different sender keeps this bit
      p_ack_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ack && 32'(req_id) == t && 32'(arg_id) != s) |=> $stable(src_vec[t][s]));
    end

    // R3: no core ever appears as a sender to itself
    p_no_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !src_vec[t][t]);
  end

  // R10: without a ring or acknowledge the vectors do not move
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_ring || do_ack) |=> $stable(src_vec));

endmodule

// File: rtl/xcd_readback.sv
module xcd_readback #(
  parameter int N    = 4,
  parameter int ID_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                do_peek,
  input  logic                do_who,
  input  logic [ID_W-1:0]     req_id,
  input  logic [ID_W-1:0]     arg_id,
  input  logic [N-1:0][N-1:0] src_vec,
  output logic [N-1:0]        rb_q
);

  logic         pend_sel;
  logic [N-1:0] own_vec;

  always_comb begin
    pend_sel = |src_vec[arg_id];
    own_vec  = src_vec[req_id];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rb_q <= '0;
    else if (do_peek) rb_q <= N'(pend_sel);
    else if (do_who)  rb_q <= own_vec;
  end

  // R4: a peek returns only a zero-extended pending flag
  p_peek_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_peek |=> (rb_q[N-1:1] == '0));

  // R10: readback is untouched when no read command ran
  p_rb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_peek || do_who) |=> $stable(rb_q));

endmodule

// File: rtl/xcd_irq_drive.sv
module xcd_irq_drive #(
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][N-1:0] src_vec,
  output logic [N-1:0]        irq_q
);

  for (genvar t = 0; t < N; t++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[t] <= 1'b0;
      else        irq_q[t] <= |src_vec[t];
    end

    // R8: the line trails its vector's OR by exactly one cycle
    p_line_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(|src_vec[t])) |=> !irq_q[t]);
  end

endmodule

// File: rtl/xcore_doorbell.sv
module xcore_doorbell #(
  parameter int N    = 4,
  parameter int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [ID_W-1:0] cmd_core,
  input  logic [15:0]     cmd_word,
  output logic [N-1:0]    readback,
  output logic [N-1:0]    irq
);

  logic                do_ring, do_peek, do_who, do_ack;
  logic [ID_W-1:0]     req_id, arg_id;
  logic [N-1:0][N-1:0] src_vec;

  xcd_cmd_stage #(.N(N), .ID_W(ID_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_core(cmd_core),
    .cmd_word(cmd_word), .do_ring(do_ring), .do_peek(do_peek),
    .do_who(do_who), .do_ack(do_ack), .req_id(req_id), .arg_id(arg_id)
  );

  xcd_sender_matrix #(.N(N), .ID_W(ID_W)) u_mat (
    .clk(clk), .rst_n(rst_n), .do_ring(do_ring), .do_ack(do_ack),
    .req_id(req_id), .arg_id(arg_id), .src_vec(src_vec)
  );

  xcd_readback #(.N(N), .ID_W(ID_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .do_peek(do_peek), .do_who(do_who),
    .req_id(req_id), .arg_id(arg_id), .src_vec(src_vec), .rb_q(readback)
  );

  xcd_irq_drive #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .irq_q(irq)
  );

  // R11: everything is quiet in the first cycle after reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq == '0 && readback == '0));

endmodule

// File: tb/xcore_doorbell_test.sv
module xcore_doorbell_test;
  localparam int N    = 4;
  localparam int ID_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_we = 1'b0;
  logic [ID_W-1:0] cmd_core = '0;
  logic [15:0]     cmd_word = '0;
  logic [N-1:0]    readback;
  logic [N-1:0]    irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [N-1:0] model [N];
  logic [N-1:0] rb_model = '0;

  xcore_doorbell #(.N(N), .ID_W(ID_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_core(cmd_core),
    .cmd_word(cmd_word), .readback(readback), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [N-1:0] irq_model();
    logic [N-1:0] v;
    for (int t = 0; t < N; t++) v[t] = |model[t];
    return v;
  endfunction

  // drive one command; returns after the edge where readback/vectors update
  task automatic send(input int core, input logic [7:0] op, input logic [7:0] arg);
    @(negedge clk);
    cmd_we   = 1'b1;
    cmd_core = ID_W'(core);
    cmd_word = {arg, op};
    @(negedge clk);
    cmd_we   = 1'b0;
    cmd_word = 16'hxxxx;
    @(negedge clk);
    // software model of the requirements
    if (core < N && int'(arg) < N) begin
      case (op)
        8'h01: if (int'(arg) != core) model[arg][core] = 1'b1;
        8'h02: rb_model = N'(|model[arg]);
        8'h03: rb_model = model[core];
        8'h04: model[core][arg] = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    for (int t = 0; t < N; t++) model[t] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 irq", irq, '0);
    check("R11 readback", readback, '0);

    // R2 R3 R4 R5 R7: sweep every sender/target pair
    for (int s = 0; s < N; s++) begin
      for (int t = 0; t < N; t++) begin
        send(s, 8'h01, 8'(t));
        settle();
        check(s == t ? "R3 self ring irq" : "R2 ring irq", irq, irq_model());
        send((t + 1) % N, 8'h02, 8'(t));
        check(s == t ? "R3 self peek" : "R4 peek", readback, rb_model);
        check("R4 peek value", readback, (s == t) ? 4'd0 : 4'd1);
        send(t, 8'h03, 8'h00);
        check("R5 who-rang", readback, (s == t) ? 4'd0 : 4'(1 << s));
        send(t, 8'h04, 8'(s));
        settle();
        check("R7 ack irq", irq, '0);
      end
    end

    // R6 R7 R8 R9: merged senders 0,1,3 to target 2
    send(0, 8'h01, 8'd2);
    send(1, 8'h01, 8'd2);
    send(3, 8'h01, 8'd2);
    settle();
    check("R6 single line", irq, 4'b0100);
    send(2, 8'h03, 8'h00);
    check("R6 merged vector", readback, 4'b1011);
    send(1, 8'h01, 8'd2);
    send(2, 8'h03, 8'h00);
    check("R9 repeat ring", readback, 4'b1011);
    send(2, 8'h04, 8'd1);
    send(2, 8'h03, 8'h00);
    check("R7 ack one bit", readback, 4'b1001);
    check("R8 still high", irq, 4'b0100);
    send(2, 8'h04, 8'd0);
    send(2, 8'h04, 8'd3);
    check("R8 high in clear cycle", irq, 4'b0100);
    settle();
    check("R8 low after last clear", irq, 4'b0000);
    send(2, 8'h03, 8'h00);
    check("R7 vector empty", readback, 4'b0000);

    // R1: argument in the high byte, not the low one
    send(0, 8'h01, 8'd3);
    settle();
    check("R1 field position", irq, 4'b1000);

    // R10: out-of-range arguments and unused opcodes
    send(1, 8'h03, 8'h00);
    check("R10 prep readback", readback, rb_model);
    send(0, 8'h01, 8'd4);
    send(0, 8'h01, 8'd9);
    send(0, 8'h01, 8'd255);
    send(3, 8'h04, 8'd7);
    send(3, 8'h02, 8'd5);
    check("R10 peek out of range", readback, rb_model);
    send(3, 8'h00, 8'd0);
    send(3, 8'hFF, 8'd0);
    send(3, 8'h05, 8'd0);
    settle();
    check("R10 lines unchanged", irq, 4'b1000);
    check("R10 readback unchanged", readback, rb_model);
    send(3, 8'h03, 8'h00);
    check("R10 vector intact", readback, 4'b0001);
    send(3, 8'h04, 8'd0);
    settle();
    check("R8 final clear", irq, 4'b0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule